// File: doc/BRIEF.md
# Half-word host bus to 32-bit word adapter

This block lets a host with a 16-bit data bus reach internal 32-bit registers and FIFO words. Each host access carries one address bit (`hb_a1`) that picks which half of the 32-bit word the access touches. A 32-bit mode register, reachable from the host through the same bus, chooses between the normal half-word mapping and the reversed one. Reversal applies only when that register holds all ones.

Writes are built from two half-word accesses. The lower half is held in a staging register. The internal write strobe fires only once the upper half arrives. Reads work the other way. When the lower half is fetched, the whole internal word is captured. The later upper-half access then returns data from that same capture, so the two halves always belong to one word. The lower half always travels first: in normal mapping that is the `hb_a1`=0 access, and in reversed mapping it is the `hb_a1`=1 access.

Top module: `hword_swap_bridge`

## Requirements
- R1: After reset the mode register reads 0 (normal mapping), `int_wr`, `int_rd` and `hb_rvalid` are low.
- R2: Reversed mapping is active only while the mode register equals 0xFFFFFFFF. Any other value, for example 0xFFFFFFFE, leaves normal mapping in force. A completed mode-register write takes effect within two cycles of its upper-half access.
- R3: In normal mapping an access with `hb_a1`=0 reaches word bits [15:0] and one with `hb_a1`=1 reaches bits [31:16].
- R4: In reversed mapping `hb_a1`=1 reaches bits [15:0] and `hb_a1`=0 reaches bits [31:16].
- R5: A lower-half write only stages its data. An upper-half write that follows a staged lower half raises `int_wr` for exactly one cycle, in the cycle after the access, with `int_wdata` = {upper, lower}. A second lower-half write replaces the staged value.
- R6: An upper-half write with no staged lower half, or one that follows a completed word, produces no `int_wr`.
- R7: A lower-half read raises `int_rd` in the access cycle and captures `int_rdata`. An upper-half read does not raise `int_rd` and returns bits [31:16] of that capture, even if `int_rdata` has changed since.
- R8: Read data appears on `hb_rdata` with `hb_rvalid` high for one cycle, in the cycle after the read access.
- R9: Byte lanes are fixed: bus bits [7:0] carry byte 0 (word bits [7:0]) and bus bits [15:8] carry byte 1 (word bits [15:8]) on the lower half. On the upper half they carry bytes 2 and 3.
- R10: With `hb_ctl`=1 accesses target the mode register instead of the internal port, using the same half-word mapping, staging and read capture. They never raise `int_wr` or `int_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_sel | input | 1 | Host access valid for this cycle |
| hb_wr | input | 1 | 1 = write access, 0 = read access |
| hb_ctl | input | 1 | 1 = access targets the mode register |
| hb_a1 | input | 1 | Half-word select address bit |
| hb_wdata | input | 16 | Host write half-word |
| hb_rdata | output | 16 | Host read half-word |
| hb_rvalid | output | 1 | `hb_rdata` valid |
| int_wr | output | 1 | Internal full-word write strobe |
| int_wdata | output | 32 | Internal write word |
| int_rd | output | 1 | Internal read request; word sampled this cycle |
| int_rdata | input | 32 | Internal read word |

## Verification
A wrong mode bit shows up at the ports on the very next access. The half-word lands in the wrong lane of `int_wdata` or returns the wrong half of `hb_rdata`, and the swapped access order makes the strobe fire early or not at all. A stale or lost staging flag shows up as a missing or extra `int_wr` one cycle after an upper-half write. A capture register that is not held shows up on the next upper-half read, as soon as `int_rdata` has been changed between the two halves.

// File: rtl/hwsw_pkg.sv
package hwsw_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/hwsw_lane_map.sv
module hwsw_lane_map
  import hwsw_pkg::*;
(
  input  logic  a1,
  input  logic  swap,
  output half_e half
);
  // reversed mapping simply inverts the half selected by the address bit
  always_comb begin
    if (swap) half = a1 ? HALF_LO : HALF_HI;
    else      half = a1 ? HALF_HI : HALF_LO;
  end
endmodule

// File: rtl/hwsw_wr_assembler.sv
module hwsw_wr_assembler
  import hwsw_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  half_e               half,
  input  logic                tgt_ctl,
  input  logic [HALF_W-1:0]   wdata,
  output logic                word_stb,
  output logic                word_ctl,
  output logic [2*HALF_W-1:0] word
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] stage_q, stage_d;
  logic              stage_vld_q, stage_vld_d;
  logic              stage_ctl_q, stage_ctl_d;
  logic              stb_q, stb_d;
  logic              ctl_q, ctl_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              load_word;

  always_comb begin
    stage_d     = stage_q;
    stage_vld_d = stage_vld_q;
    stage_ctl_d = stage_ctl_q;
    stb_d       = 1'b0;
    ctl_d       = ctl_q;
    load_word   = 1'b0;
    word_d      = word_q;
    if (acc && half == HALF_LO) begin
      stage_d     = wdata;
      stage_vld_d = 1'b1;
      stage_ctl_d = tgt_ctl;
    end else if (acc && half == HALF_HI) begin
      stage_vld_d = 1'b0;
      if (stage_vld_q && stage_ctl_q == tgt_ctl) begin
        stb_d     = 1'b1;
        ctl_d     = tgt_ctl;
        load_word = 1'b1;
        word_d    = {wdata, stage_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      stage_vld_q <= 1'b0;
      stage_ctl_q <= 1'b0;
      stb_q       <= 1'b0;
      ctl_q       <= 1'b0;
      word_q      <= '0;
    end else begin
      stb_q       <= stb_d;
      stage_vld_q <= stage_vld_d;
      if (acc) begin
        stage_q     <= stage_d;
        stage_ctl_q <= stage_ctl_d;
      end
      if (load_word) begin
        ctl_q  <= ctl_d;
        word_q <= word_d;
      end
    end
  end

  assign word_stb = stb_q;
  assign word_ctl = ctl_q;
  assign word     = word_q;

  // R5: a completed word strobes for one cycle only
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R5 / R6: a strobe is always preceded by an upper-half write access
  a_r6_hi_before_stb: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(acc && half == HALF_HI));
endmodule

// File: rtl/hwsw_rd_splitter.sv
module hwsw_rd_splitter
  import hwsw_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  half_e               half,
  input  logic                tgt_ctl,
  input  logic [2*HALF_W-1:0] int_rdata,
  input  logic [2*HALF_W-1:0] ctl_value,
  output logic                int_rd,
  output logic [HALF_W-1:0]   rdata,
  output logic                rvalid
);
  localparam int WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] snap_q, snap_d, src;
  logic [HALF_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic              take_lo;

  always_comb begin
    take_lo = acc && (half == HALF_LO);
    src     = tgt_ctl ? ctl_value : int_rdata;
    snap_d  = snap_q;
    rdata_d = rdata_q;
    if (take_lo) begin
      snap_d  = src;
      rdata_d = src[HALF_W-1:0];
    end else if (acc) begin
      rdata_d = snap_q[WORD_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= acc;
      if (take_lo) snap_q  <= snap_d;
      if (acc)     rdata_q <= rdata_d;
    end
  end

  assign int_rd = take_lo && !tgt_ctl;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R7: the capture only moves on a lower-half read
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && half == HALF_LO) |=> $stable(snap_q));
  // R8: valid data only follows a read access
  a_r8_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |-> $past(acc));
endmodule

// File: rtl/hword_swap_bridge.sv
module hword_swap_bridge
  import hwsw_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hb_sel,
  input  logic                hb_wr,
  input  logic                hb_ctl,
  input  logic                hb_a1,
  input  logic [HALF_W-1:0]   hb_wdata,
  output logic [HALF_W-1:0]   hb_rdata,
  output logic                hb_rvalid,
  output logic                int_wr,
  output logic [2*HALF_W-1:0] int_wdata,
  output logic                int_rd,
  input  logic [2*HALF_W-1:0] int_rdata
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [WORD_W-1:0] SWAP_KEY = '1;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic [WORD_W-1:0] mode_q, mode_d;
  logic              swap;
  half_e             half;
  logic              wr_acc, rd_acc;
  logic              stb, stb_ctl;
  logic [WORD_W-1:0] word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign swap   = (mode_q == SWAP_KEY);
  assign wr_acc = hb_sel && hb_wr;
  assign rd_acc = hb_sel && !hb_wr;

  hwsw_lane_map i_lane_map (
    .a1   (hb_a1),
    .swap (swap),
    .half (half)
  );

  hwsw_wr_assembler #(.HALF_W(HALF_W)) i_wr_asm (
    .clk      (clk),
    .rst_n    (rst_s),
    .acc      (wr_acc),
    .half     (half),
    .tgt_ctl  (hb_ctl),
    .wdata    (hb_wdata),
    .word_stb (stb),
    .word_ctl (stb_ctl),
    .word     (word)
  );

  hwsw_rd_splitter #(.HALF_W(HALF_W)) i_rd_split (
    .clk       (clk),
    .rst_n     (rst_s),
    .acc       (rd_acc),
    .half      (half),
    .tgt_ctl   (hb_ctl),
    .int_rdata (int_rdata),
    .ctl_value (mode_q),
    .int_rd    (int_rd),
    .rdata     (hb_rdata),
    .rvalid    (hb_rvalid)
  );

  always_comb begin
    mode_d = mode_q;
    if (stb && stb_ctl) mode_d = word;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)              mode_q <= '0;
    else if (stb && stb_ctl) mode_q <= mode_d;
  end

  assign int_wr    = stb && !stb_ctl;
  assign int_wdata = word;

  // R2: the mode register only changes after a completed mode write
  a_r2_mode_by_write: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(mode_q) |-> $past(stb && stb_ctl));
  // R10: mode-register traffic never reaches the internal port
  a_r10_ctl_isolated: assert property (@(posedge clk) disable iff (!rst_s)
    (hb_sel && hb_ctl) |-> !int_rd);
endmodule

// File: tb/test_hword_swap_bridge.sv
module test_hword_swap_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hb_sel, hb_wr, hb_ctl, hb_a1;
  logic [15:0] hb_wdata, hb_rdata;
  logic        hb_rvalid, int_wr, int_rd;
  logic [31:0] int_wdata, int_rdata;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic [31:0] last_word = '0;
  bit   done = 0;

  always #5 clk = ~clk;

  hword_swap_bridge i_hword_swap_bridge (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_ctl(hb_ctl),
    .hb_a1(hb_a1), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_rvalid(hb_rvalid),
    .int_wr(int_wr), .int_wdata(int_wdata), .int_rd(int_rd), .int_rdata(int_rdata)
  );

  always @(negedge clk) if (int_wr) begin
    strobes++;
    last_word = int_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic ctl, input logic wr, input logic a1, input logic [15:0] d,
                     output logic [15:0] rd, output logic rv, output logic saw_rd);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = wr; hb_ctl = ctl; hb_a1 = a1; hb_wdata = d;
    #1 saw_rd = int_rd;
    @(negedge clk);
    hb_sel = 1'b0;
    rd = hb_rdata; rv = hb_rvalid;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {a1_first, d_first, a1_second, d_second, strobe_count, last_word}
  localparam logic [67:0] VEC [6] = '{
    {1'b0, 16'h1234, 1'b1, 16'hABCD, 2'd1, 32'hABCD1234},
    {1'b0, 16'h00FF, 1'b1, 16'hFF00, 2'd1, 32'hFF0000FF},
    {1'b1, 16'h5555, 1'b0, 16'hAAAA, 2'd0, 32'hFF0000FF},
    {1'b0, 16'h0001, 1'b1, 16'h8000, 2'd1, 32'h80000001},
    {1'b0, 16'h1111, 1'b0, 16'h2222, 2'd0, 32'h80000001},
    {1'b1, 16'h3333, 1'b1, 16'h4444, 2'd1, 32'h33332222}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic rv, srd;
    int s0;
    rst_n = 1'b0; hb_sel = 0; hb_wr = 0; hb_ctl = 0; hb_a1 = 0; hb_wdata = '0;
    int_rdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    chk("R1 int_wr", {31'b0, int_wr}, 32'd0);
    chk("R1 rvalid", {31'b0, hb_rvalid}, 32'd0);
    chk("R1 int_rd", {31'b0, int_rd}, 32'd0);
    acc(1, 0, 0, 16'h0, rd, rv, srd);
    chk("R1 R10 mode lo", {16'h0, rd}, 32'h0);
    chk("R10 no int_rd on ctl", {31'b0, srd}, 32'd0);
    acc(1, 0, 1, 16'h0, rd, rv, srd);
    chk("R1 mode hi", {16'h0, rd}, 32'h0);

    // R5 R6 R3: write table in normal mapping
    foreach (VEC[i]) begin
      s0 = strobes;
      acc(0, 1, VEC[i][67], VEC[i][66:51], rd, rv, srd);
      acc(0, 1, VEC[i][50], VEC[i][49:34], rd, rv, srd);
      idle(1);
      chk("R5 R6 strobe count", strobes - s0, {30'b0, VEC[i][33:32]});
      chk("R5 R3 word", last_word, VEC[i][31:0]);
    end
    // R5: strobe lasts exactly one cycle
    s0 = strobes;
    acc(0, 1, 0, 16'hBEEF, rd, rv, srd);
    acc(0, 1, 1, 16'hDEAD, rd, rv, srd);
    chk("R5 strobe high", {31'b0, int_wr}, 32'd1);
    idle(1);
    chk("R5 strobe one cycle", {31'b0, int_wr}, 32'd0);
    // R6: upper half after a completed word is ignored
    acc(0, 1, 1, 16'h7777, rd, rv, srd);
    idle(1);
    chk("R6 no strobe", strobes - s0, 32'd1);

    // R7 R8 R3 R9: split read in normal mapping
    int_rdata = 32'h44332211;
    acc(0, 0, 0, 16'h0, rd, rv, srd);
    chk("R7 int_rd on lower", {31'b0, srd}, 32'd1);
    chk("R8 rvalid", {31'b0, rv}, 32'd1);
    chk("R9 byte0", {24'h0, rd[7:0]}, 32'h11);
    chk("R9 byte1", {24'h0, rd[15:8]}, 32'h22);
    idle(1);
    chk("R8 rvalid one cycle", {31'b0, hb_rvalid}, 32'd0);
    int_rdata = 32'hCAFEF00D;
    acc(0, 0, 1, 16'h0, rd, rv, srd);
    chk("R7 no int_rd on upper", {31'b0, srd}, 32'd0);
    chk("R7 R3 R9 upper from capture", {16'h0, rd}, 32'h4433);

    // R2: near-miss value keeps normal mapping
    acc(1, 1, 0, 16'hFFFE, rd, rv, srd);
    acc(1, 1, 1, 16'hFFFF, rd, rv, srd);
    idle(2);
    acc(1, 0, 0, 16'h0, rd, rv, srd);
    chk("R10 mode readback lo", {16'h0, rd}, 32'hFFFE);
    s0 = strobes;
    acc(0, 1, 0, 16'h0102, rd, rv, srd);
    acc(0, 1, 1, 16'h0304, rd, rv, srd);
    idle(1);
    chk("R2 near-miss normal", last_word, 32'h03040102);
    chk("R10 ctl write no strobe", strobes - s0, 32'd1);

    // R2 R4: all ones switches to reversed mapping
    acc(1, 1, 0, 16'hFFFF, rd, rv, srd);
    acc(1, 1, 1, 16'hFFFF, rd, rv, srd);
    idle(2);
    s0 = strobes;
    acc(0, 1, 1, 16'h5678, rd, rv, srd);
    acc(0, 1, 0, 16'h9ABC, rd, rv, srd);
    idle(1);
    chk("R4 swap write", last_word, 32'h9ABC5678);
    chk("R4 swap strobe", strobes - s0, 32'd1);
    // R6: in reversed mapping a1=0 first is an orphan upper half
    acc(0, 1, 0, 16'h1357, rd, rv, srd);
    idle(1);
    chk("R6 swap orphan", strobes - s0, 32'd1);
    int_rdata = 32'h89ABCDEF;
    acc(0, 0, 1, 16'h0, rd, rv, srd);
    chk("R4 R7 swap lower read", {15'h0, srd, rd}, 32'h1CDEF);
    int_rdata = 32'h0;
    acc(0, 0, 0, 16'h0, rd, rv, srd);
    chk("R4 R7 swap upper read", {15'h0, srd, rd}, 32'h089AB);

    // R2: back to zero in reversed order, normal mapping returns
    acc(1, 1, 1, 16'h0000, rd, rv, srd);
    acc(1, 1, 0, 16'h0000, rd, rv, srd);
    idle(2);
    acc(0, 1, 0, 16'hAAAA, rd, rv, srd);
    acc(0, 1, 1, 16'hBBBB, rd, rv, srd);
    idle(1);
    chk("R2 back to normal", last_word, 32'hBBBBAAAA);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule